// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block gathers one or more sector erase requests into a per-sector selection bitmap before any erasing takes place. The first sector erase command opens an acceptance window. Each later sector erase command adds its sector to the bitmap and restarts the window, and the sectors may be named in any order. Any other command that arrives while the window is open cancels the whole request. When the window runs out with no new command, the block passes the selected sectors to an erase engine, lowest sector number first. It waits for the engine's done pulse before it moves to the next sector.

Its inputs are command events that the bus decoder has already decoded, plus a done strobe from the engine. The physical erase is outside this block. The window length is a parameter counted in clock cycles. Its default matches 50 ms at 125 MHz.

The controller has three states:
- `ST_READ_ARRAY` is idle.
- `ST_COLLECT` is the window open.
- `ST_ERASING` is the hand-off to the engine.

The transitions are:
- *open*: `ST_READ_ARRAY`→`ST_COLLECT`, on a sector erase command.
- *extend*: `ST_COLLECT`→`ST_COLLECT`, on a sector erase command, which restarts the window.
- *abort*: `ST_COLLECT`→`ST_READ_ARRAY`, on any other command.
- *expire*: `ST_COLLECT`→`ST_ERASING`, when the window runs out.
- *finish*: `ST_ERASING`→`ST_READ_ARRAY`, on the done pulse for the last selected sector.

Top module: `se_erase_collector`

## Requirements
- R1: While reset is held, and at the first sampling after it is released, `sector_map` is 0 and `busy`, `erase_req` and `dq3_timer` are 0. A reset asserted during collection discards the selection.
- R2: In `ST_READ_ARRAY`, a command with `cmd_sector_erase`=1 sets bit `cmd_sector` of `sector_map` and raises `busy` at the same edge, with `dq3_timer` staying 0. Any other command in this state leaves all outputs at their idle values.
- R3: In `ST_COLLECT`, each sector erase command sets its sector's bit and restarts the window. Sectors may arrive in any order. A sector that is already selected leaves the bitmap unchanged. A command accepted at the very edge at which the window would have closed still restarts it.
- R4: When WINDOW_CYCLES consecutive clock edges pass with no command after the last accepted sector erase command, the block enters `ST_ERASING` at that last edge. `dq3_timer` and `erase_req` go to 1 there. `dq3_timer` stays 0 while the window is open.
- R5: Any command with `cmd_sector_erase`=0 during `ST_COLLECT` clears the whole bitmap and returns to `ST_READ_ARRAY` (`busy`=0) at the same edge.
- R6: In `ST_ERASING`, every command is ignored. The bitmap changes only through `eng_done`.
- R7: `erase_sector` always shows the lowest set bit of `sector_map`, or 0 if the bitmap is empty. An `eng_done` pulse in `ST_ERASING` clears that bit, so the sectors are erased in ascending order.
- R8: The `eng_done` that clears the last selected bit returns the block to `ST_READ_ARRAY`, with `busy`, `erase_req` and `dq3_timer` all at 0.
- R9: `eng_done` outside `ST_ERASING` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One decoded command is present this cycle |
| cmd_sector_erase | input | 1 | 1: the command is sector erase; 0: any other command |
| cmd_sector | input | SEC_W | Sector number carried by a sector erase command |
| eng_done | input | 1 | Engine has finished erasing `erase_sector` |
| sector_map | output | NUM_SECTORS | One bit per selected sector still to be erased |
| erase_sector | output | SEC_W | Lowest selected sector, which is the current erase target |
| erase_req | output | 1 | Engine should erase `erase_sector` |
| busy | output | 1 | High whenever the block is not in read-array mode |
| dq3_timer | output | 1 | Status bit 3: 0 while the window accepts sectors, 1 once erasing has started |

## Verification
The bench builds the block with NUM_SECTORS=8 and WINDOW_CYCLES=4. The short window makes the expiry edge, and a restart on the very cycle of expiry, reachable within a few cycles of a vector table. With eight sectors, a full selection entered in descending order can be drained and checked against the ascending erase order in tens of cycles.

// File: rtl/se_acc_pkg.sv
package se_acc_pkg;

    typedef enum logic [1:0] {
        ST_READ_ARRAY = 2'd0,
        ST_COLLECT    = 2'd1,
        ST_ERASING    = 2'd2
    } se_state_t;

endpackage

// File: rtl/se_window_timer.sv
module se_window_timer #(
    parameter int unsigned WINDOW_CYCLES = 6_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int unsigned CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run || restart) begin
            count <= '0;
        end else if (count != LAST) begin
            count <= count + 1'b1;
        end
    end

    always_comb begin
        expired = run && (count == LAST);
    end

    // R4: the quiet-cycle count never runs past the window length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);

endmodule

// File: rtl/se_lowest_pick.sv
module se_lowest_pick #(
    parameter int unsigned NUM_SECTORS = 8,
    parameter int unsigned SEC_W       = 3
) (
    input  logic [NUM_SECTORS-1:0] map,
    output logic [SEC_W-1:0]       idx,
    output logic                   any
);
    always_comb begin
        idx = '0;
        for (int i = NUM_SECTORS - 1; i >= 0; i--) begin
            if (map[i]) begin
                idx = SEC_W'(i);
            end
        end
        any = |map;
    end

endmodule

// File: rtl/se_sector_map.sv
module se_sector_map #(
    parameter int unsigned NUM_SECTORS = 8,
    parameter int unsigned SEC_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_all,
    input  logic                   set_en,
    input  logic [SEC_W-1:0]       set_idx,
    input  logic                   clr_en,
    input  logic [SEC_W-1:0]       clr_idx,
    output logic [NUM_SECTORS-1:0] map
);
    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map[g] <= 1'b0;
            end else if (clear_all) begin
                map[g] <= 1'b0;
            end else if (set_en && (set_idx == SEC_W'(g))) begin
                map[g] <= 1'b1;
            end else if (clr_en && (clr_idx == SEC_W'(g))) begin
                map[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/se_erase_collector.sv
module se_erase_collector
    import se_acc_pkg::*;
#(
    parameter int unsigned NUM_SECTORS   = 8,
    parameter int unsigned WINDOW_CYCLES = 6_250_000,
    localparam int unsigned SEC_W        = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic                   cmd_sector_erase,
    input  logic [SEC_W-1:0]       cmd_sector,
    input  logic                   eng_done,
    output logic [NUM_SECTORS-1:0] sector_map,
    output logic [SEC_W-1:0]       erase_sector,
    output logic                   erase_req,
    output logic                   busy,
    output logic                   dq3_timer
);
    se_state_t state, state_nx;

    logic sector_ok;
    logic accept_se;
    logic abort_req;
    logic win_expired;
    logic pick_any;
    logic clr_now;
    logic last_one;

    always_comb begin
        sector_ok = ({1'b0, cmd_sector} < (SEC_W + 1)'(NUM_SECTORS));
        accept_se = cmd_valid && cmd_sector_erase && sector_ok && (state != ST_ERASING);
        abort_req = cmd_valid && !cmd_sector_erase && (state == ST_COLLECT);
        clr_now   = (state == ST_ERASING) && eng_done && pick_any;
        last_one  = ($countones(sector_map) == 1);
    end

    se_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_COLLECT),
        .restart (accept_se),
        .expired (win_expired)
    );

    se_sector_map #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (abort_req),
        .set_en    (accept_se),
        .set_idx   (cmd_sector),
        .clr_en    (clr_now),
        .clr_idx   (erase_sector),
        .map       (sector_map)
    );

    se_lowest_pick #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_pick (
        .map (sector_map),
        .idx (erase_sector),
        .any (pick_any)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READ_ARRAY: begin
                if (accept_se) state_nx = ST_COLLECT;               // open
            end
            ST_COLLECT: begin
                if (abort_req)        state_nx = ST_READ_ARRAY;     // abort
                else if (accept_se)   state_nx = ST_COLLECT;        // extend
                else if (win_expired) state_nx = ST_ERASING;        // expire
            end
            ST_ERASING: begin
                if (clr_now && last_one) state_nx = ST_READ_ARRAY;  // finish
            end
            default: state_nx = ST_READ_ARRAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READ_ARRAY;
        else        state <= state_nx;
    end

    always_comb begin
        busy      = (state != ST_READ_ARRAY);
        erase_req = (state == ST_ERASING);
        dq3_timer = (state == ST_ERASING);
    end

    // R2: an accepted sector erase command leaves its bit set
    a_r2_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        accept_se |=> sector_map[$past(cmd_sector)]);

    // R3: an accepted command keeps the window open
    a_r3_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        accept_se |=> (busy && !dq3_timer));

    // R5: a foreign command in the window drops everything
    a_r5_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && cmd_valid && !cmd_sector_erase) |=> (sector_map == '0 && !busy));

    // R6: while erasing, the bitmap moves only on done
    a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING && !eng_done) |=> $stable(sector_map));

    // R7: done clears the sector that was being erased
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING && eng_done) |=> !sector_map[$past(erase_sector)]);

    // R7: the erase target is always a selected sector
    a_r7_target_selected: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> sector_map[erase_sector]);

    // R8: whenever busy, there is still work selected
    a_r8_busy_has_work: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sector_map != '0));

endmodule

// File: tb/se_erase_collector_test.sv
module se_erase_collector_test;

    localparam int unsigned NS = 8;
    localparam int unsigned WC = 4;
    localparam int NV = 29;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_sector_erase = 1'b0;
    logic [2:0] cmd_sector = 3'd0;
    logic       eng_done = 1'b0;
    logic [7:0] sector_map;
    logic [2:0] erase_sector;
    logic       erase_req;
    logic       busy;
    logic       dq3_timer;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    se_erase_collector #(.NUM_SECTORS(NS), .WINDOW_CYCLES(WC)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_valid        (cmd_valid),
        .cmd_sector_erase (cmd_sector_erase),
        .cmd_sector       (cmd_sector),
        .eng_done         (eng_done),
        .sector_map       (sector_map),
        .erase_sector     (erase_sector),
        .erase_req        (erase_req),
        .busy             (busy),
        .dq3_timer        (dq3_timer)
    );

    // Vector layout: {req tag[4], valid, is_se, sector[3], done,
    //                 exp map[8], exp busy, exp dq3, exp req, exp cur[3]}
    localparam logic [23:0] VECS [NV] = '{
        {4'd2, 1'b0,1'b0,3'd0,1'b0, 8'h00,1'b0,1'b0,1'b0,3'd0}, // R2 idle, nothing
        {4'd2, 1'b1,1'b0,3'd0,1'b0, 8'h00,1'b0,1'b0,1'b0,3'd0}, // R2 foreign in idle ignored
        {4'd9, 1'b0,1'b0,3'd0,1'b1, 8'h00,1'b0,1'b0,1'b0,3'd0}, // R9 done in idle ignored
        {4'd2, 1'b1,1'b1,3'd5,1'b0, 8'h20,1'b1,1'b0,1'b0,3'd5}, // R2 open with sector 5
        {4'd3, 1'b1,1'b1,3'd2,1'b0, 8'h24,1'b1,1'b0,1'b0,3'd2}, // R3 add sector 2
        {4'd3, 1'b1,1'b1,3'd2,1'b0, 8'h24,1'b1,1'b0,1'b0,3'd2}, // R3 duplicate
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h24,1'b1,1'b0,1'b0,3'd2}, // R4 quiet 1
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h24,1'b1,1'b0,1'b0,3'd2}, // R4 quiet 2
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h24,1'b1,1'b0,1'b0,3'd2}, // R4 quiet 3
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h24,1'b1,1'b1,1'b1,3'd2}, // R4 quiet 4: erasing
        {4'd6, 1'b1,1'b1,3'd0,1'b0, 8'h24,1'b1,1'b1,1'b1,3'd2}, // R6 sector erase ignored
        {4'd6, 1'b1,1'b0,3'd0,1'b0, 8'h24,1'b1,1'b1,1'b1,3'd2}, // R6 foreign ignored
        {4'd7, 1'b0,1'b0,3'd0,1'b1, 8'h20,1'b1,1'b1,1'b1,3'd5}, // R7 sector 2 done
        {4'd7, 1'b0,1'b0,3'd0,1'b0, 8'h20,1'b1,1'b1,1'b1,3'd5}, // R7 wait
        {4'd8, 1'b0,1'b0,3'd0,1'b1, 8'h00,1'b0,1'b0,1'b0,3'd0}, // R8 last done
        {4'd2, 1'b1,1'b1,3'd7,1'b0, 8'h80,1'b1,1'b0,1'b0,3'd7}, // R2 open sector 7
        {4'd3, 1'b1,1'b1,3'd1,1'b0, 8'h82,1'b1,1'b0,1'b0,3'd1}, // R3 add sector 1
        {4'd5, 1'b1,1'b0,3'd0,1'b0, 8'h00,1'b0,1'b0,1'b0,3'd0}, // R5 abort
        {4'd2, 1'b1,1'b1,3'd3,1'b0, 8'h08,1'b1,1'b0,1'b0,3'd3}, // R2 open sector 3
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h08,1'b1,1'b0,1'b0,3'd3}, // R4 quiet 1
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h08,1'b1,1'b0,1'b0,3'd3}, // R4 quiet 2
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h08,1'b1,1'b0,1'b0,3'd3}, // R4 quiet 3
        {4'd3, 1'b1,1'b1,3'd6,1'b0, 8'h48,1'b1,1'b0,1'b0,3'd3}, // R3 restart at expiry edge
        {4'd3, 1'b0,1'b0,3'd0,1'b0, 8'h48,1'b1,1'b0,1'b0,3'd3}, // R3 quiet 1
        {4'd3, 1'b0,1'b0,3'd0,1'b0, 8'h48,1'b1,1'b0,1'b0,3'd3}, // R3 quiet 2
        {4'd3, 1'b0,1'b0,3'd0,1'b0, 8'h48,1'b1,1'b0,1'b0,3'd3}, // R3 quiet 3
        {4'd4, 1'b0,1'b0,3'd0,1'b0, 8'h48,1'b1,1'b1,1'b1,3'd3}, // R4 quiet 4: erasing
        {4'd6, 1'b1,1'b0,3'd0,1'b1, 8'h40,1'b1,1'b1,1'b1,3'd6}, // R6 done plus foreign
        {4'd8, 1'b0,1'b0,3'd0,1'b1, 8'h00,1'b0,1'b0,1'b0,3'd0}  // R8 finish
    };

    function automatic logic [13:0] outs();
        return {sector_map, busy, dq3_timer, erase_req, erase_sector};
    endfunction

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got map=%h busy=%b dq3=%b req=%b cur=%0d, want map=%h busy=%b dq3=%b req=%b cur=%0d",
                     tag, act[13:6], act[5], act[4], act[3], act[2:0],
                     exp[13:6], exp[5], exp[4], exp[3], exp[2:0]);
        end
    endtask

    task automatic step(input logic v, input logic se, input logic [2:0] sec, input logic d);
        @(negedge clk);
        cmd_valid = v;
        cmd_sector_erase = se;
        cmd_sector = sec;
        eng_done = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not end, got timeout, want completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", outs(), 14'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", outs(), 14'h0000);

        for (int k = 0; k < NV; k++) begin
            step(VECS[k][19], VECS[k][18], VECS[k][17:15], VECS[k][14]);
            if (outs() !== VECS[k][13:0]) begin
                $display("  vector %0d tag R%0d", k, VECS[k][23:20]);
            end
            check($sformatf("R%0d vector %0d", VECS[k][23:20], k), outs(), VECS[k][13:0]);
        end

        // R3 all sectors, descending order, then R4 exact expiry and R7 ascending drain
        for (int s = 7; s >= 0; s--) begin
            step(1'b1, 1'b1, 3'(s), 1'b0);
        end
        check("R3 all sectors selected", outs(), {8'hFF, 1'b1, 1'b0, 1'b0, 3'd0});
        for (int q = 1; q < WC; q++) begin
            step(1'b0, 1'b0, 3'd0, 1'b0);
        end
        check("R4 window still open", outs(), {8'hFF, 1'b1, 1'b0, 1'b0, 3'd0});
        step(1'b0, 1'b0, 3'd0, 1'b0);
        check("R4 window expired", outs(), {8'hFF, 1'b1, 1'b1, 1'b1, 3'd0});
        for (int s = 0; s < 8; s++) begin
            check($sformatf("R7 target %0d", s), {5'd0, erase_req, 5'd0, erase_sector}, {5'd0, 1'b1, 5'd0, 3'(s)});
            step(1'b0, 1'b0, 3'd0, 1'b1);
        end
        step(1'b0, 1'b0, 3'd0, 1'b0);
        check("R8 idle after drain", outs(), 14'h0000);

        // R1 reset during collection
        step(1'b1, 1'b1, 3'd4, 1'b0);
        check("R2 open before reset", outs(), {8'h10, 1'b1, 1'b0, 1'b0, 3'd4});
        @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset mid-collect", outs(), 14'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule